// File: doc/BRIEF.md
# Prescaled Free-Running Timer Counter

This block is a 16-bit up-counter that advances on a tick taken from a prescaler running off the bus clock. The divide ratio is fixed by a parameter, from 1 to 128 in powers of two. A small byte-addressed register window exposes the counter as two bytes and holds a control register. The control register carries an enable bit and a stop-in-wait bit. The block also produces a divide-by-64 tick for a neighbouring pulse accumulator and a one-cycle strobe each time the counter wraps.

Software may read the counter at any time. A 16-bit read at the counter's base offset returns both bytes as they stood in the same clock. Two single-byte reads can see different values, because there is no holding latch. Loads of the counter are accepted only while the chip's special-mode input is high. A load restarts the count, but the prescaler keeps its phase, so the first interval after a load may be shorter than a full prescaler period. Clearing the enable bit halts the prescaler, the counter and the divide-by-64 tick. Setting stop-in-wait does the same while the wait-mode input is high.

Read data is registered: a read presented in one cycle shows on `bus_rdata` after the next rising edge.

Top module: `ptc_top`

## Requirements
- R1: After synchronous reset the counter is 0x0000, the control register is 0x00, and `bus_rdata`, `pa_div64_tick` and `ovf_pulse` are all 0.
- R2: While the timer runs, the prescaler advances by one each clock. The counter increments at every edge where the low PRE_SHIFT prescaler bits are all ones, which gives one step per 2^PRE_SHIFT clocks (4 with the default PRE_SHIFT=2).
- R3: The counter wraps from 0xFFFF to 0x0000. `ovf_pulse` is high for exactly the one cycle in which the counter first holds 0x0000.
- R4: With `special_mode` low, any write to offset 0 or offset 1 leaves the counter unchanged.
- R5: With `special_mode` high, writes load the counter, and a load takes priority over an increment in the same cycle:
  - a word write (`bus_word`=1) at offset 0 loads all 16 bits;
  - a byte write at offset 0 loads bits 15..8 from `bus_wdata[7:0]`;
  - a byte write at offset 1 loads bits 7..0.
  A load does not reset the prescaler.
- R6: A read is captured at the next rising edge and held until the next read:
  - a word read at offset 0 returns {high byte, low byte} from that same edge;
  - a byte read at offset 0 returns the high byte in bits 7..0;
  - a byte read at offset 1 returns the low byte;
  - upper result bits are zero for byte reads.
  `bus_word` is honoured only at offset 0.
- R7: The control register is at offset 2:
  - bit 7 is enable, bit 6 is stop-in-wait;
  - bits 5..4 are stored and read back but have no effect;
  - bits 3..0 read as zero whatever is written.
  Offset 3 reads as zero.
- R8: With enable at 0, the prescaler and counter hold their values and `pa_div64_tick` stays low.
- R9: While the timer runs, `pa_div64_tick` is a one-cycle pulse once every 64 clocks.
- R10: With stop-in-wait at 1 and `wait_mode` high, the timer halts as in R8. With stop-in-wait at 0 it keeps counting while `wait_mode` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| special_mode | input | 1 | High enables counter loads |
| wait_mode | input | 1 | Chip is in wait |
| bus_addr | input | 2 | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_word | input | 1 | 16-bit access (offset 0 only) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pa_div64_tick | output | 1 | Divide-by-64 tick for the pulse accumulator |
| ovf_pulse | output | 1 | Counter wrap strobe |

## Verification
The bench loads 0xFFFE and watches for exactly one wrap strobe. A design with the strobe on the wrong edge, or held for more than one cycle, would show a different pulse count or timing. Normal-mode writes are aimed at a stopped counter, so any leak of the write path shows up as a changed value. Special-mode byte loads are checked to replace only their own byte. Random traffic, with loads landing mid-period, catches a design that resets the prescaler on a load, because its count drifts from the reference model. It also catches a design that returns bytes from different edges on word reads. Counts of divide-by-64 pulses taken while disabled, while stopped in wait and while running expose gating that is wrong or leaky.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI = 2'd0;
  localparam logic [ADDR_W-1:0] OFF_CNT_LO = 2'd1;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 2'd2;

  typedef struct packed {
    logic       enable;
    logic       stop_in_wait;
    logic [1:0] spare;
  } ctrl_t;
endpackage

// File: rtl/ptc_prescaler.sv
module ptc_prescaler #(
  parameter int PRE_SHIFT = 2,
  parameter int PRE_W     = 7,
  parameter int DIV_BITS  = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic inc,
  output logic div_tick
);
  logic [PRE_W-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre      <= '0;
      div_tick <= 1'b0;
    end else begin
      if (run) pre <= pre + 1'b1;
      div_tick <= run && (&pre[DIV_BITS-1:0]);
    end
  end

  generate
    if (PRE_SHIFT == 0) begin : g_div1
      assign inc = run;
    end else begin : g_divn
      assign inc = run && (&pre[PRE_SHIFT-1:0]);
    end
  endgenerate

  a_r8_pre_hold: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(pre));
  a_r8_no_tick: assert property (@(posedge clk) disable iff (rst)
    !run |=> !div_tick);
  a_r9_single: assert property (@(posedge clk) disable iff (rst)
    div_tick |=> !div_tick);
endmodule

// File: rtl/ptc_count16.sv
module ptc_count16 #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             ld_hi,
  input  logic             ld_lo,
  input  logic [CNT_W-1:0] ld_data,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam int HALF = CNT_W / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (ld_hi || ld_lo) begin
      if (ld_hi) cnt[CNT_W-1:HALF] <= ld_data[CNT_W-1:HALF];
      if (ld_lo) cnt[HALF-1:0]     <= ld_data[HALF-1:0];
      ovf <= 1'b0;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
      ovf <= &cnt;
    end else begin
      ovf <= 1'b0;
    end
  end

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld_hi && !ld_lo) |=> cnt == $past(cnt) + 1'b1);
  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    ovf |-> cnt == '0);
  a_r8_idle: assert property (@(posedge clk) disable iff (rst)
    (!inc && !ld_hi && !ld_lo) |=> $stable(cnt));
endmodule

// File: rtl/ptc_regs.sv
module ptc_regs
  import ptc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              special_mode,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_word,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]  cnt,
  output ctrl_t             ctrl,
  output logic              ld_hi,
  output logic              ld_lo,
  output logic [CNT_W-1:0]  ld_data,
  output logic [CNT_W-1:0]  rdata
);
  localparam int HALF = CNT_W / 2;
  logic word_at_base;

  assign word_at_base = bus_word && (bus_addr == OFF_CNT_HI);
  assign ld_hi   = bus_wr && special_mode && (bus_addr == OFF_CNT_HI);
  assign ld_lo   = bus_wr && special_mode &&
                   ((bus_addr == OFF_CNT_LO) || word_at_base);
  assign ld_data = word_at_base ? bus_wdata
                                : {bus_wdata[HALF-1:0], bus_wdata[HALF-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (bus_wr && bus_addr == OFF_CTRL) begin
      ctrl <= bus_wdata[HALF-1:HALF-4];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        OFF_CNT_HI: rdata <= word_at_base ? cnt
                                          : {{HALF{1'b0}}, cnt[CNT_W-1:HALF]};
        OFF_CNT_LO: rdata <= {{HALF{1'b0}}, cnt[HALF-1:0]};
        OFF_CTRL:   rdata <= {{HALF{1'b0}}, ctrl, 4'h0};
        default:    rdata <= '0;
      endcase
    end
  end

  a_r7_ctrl_read: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFF_CTRL) |=> rdata[3:0] == 4'h0);
  a_r6_word_coherent: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && word_at_base) |=> rdata == $past(cnt));
endmodule

// File: rtl/ptc_top.sv
module ptc_top
  import ptc_pkg::*;
#(
  parameter int PRE_SHIFT = 2,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              special_mode,
  input  logic              wait_mode,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_word,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              pa_div64_tick,
  output logic              ovf_pulse
);
  localparam int PRE_W = 7;

  ctrl_t            ctrl;
  logic             run, inc, ld_hi, ld_lo;
  logic [CNT_W-1:0] ld_data, cnt;

  assign run = ctrl.enable && !(ctrl.stop_in_wait && wait_mode);

  ptc_prescaler #(.PRE_SHIFT(PRE_SHIFT), .PRE_W(PRE_W), .DIV_BITS(6)) u_pre (
    .clk(clk), .rst(rst), .run(run), .inc(inc), .div_tick(pa_div64_tick));

  ptc_count16 #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(inc), .ld_hi(ld_hi), .ld_lo(ld_lo),
    .ld_data(ld_data), .cnt(cnt), .ovf(ovf_pulse));

  ptc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .special_mode(special_mode), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .cnt(cnt), .ctrl(ctrl), .ld_hi(ld_hi),
    .ld_lo(ld_lo), .ld_data(ld_data), .rdata(bus_rdata));

  a_r4_normal_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !special_mode && !inc) |=> $stable(cnt));
  a_r10_wait_stop: assert property (@(posedge clk) disable iff (rst)
    (ctrl.enable && ctrl.stop_in_wait && wait_mode && !ld_hi && !ld_lo)
      |=> $stable(cnt));
endmodule

// File: tb/ptc_top_test.sv
`timescale 1ns/100ps
module ptc_top_test;
  localparam int PRE_SHIFT = 2;
  localparam logic [6:0] MASK = 7'((1 << PRE_SHIFT) - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic special_mode = 1'b0, wait_mode = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0, bus_word = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic pa_div64_tick, ovf_pulse;

  int checks = 0, fails = 0;
  bit checking = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ptc_top #(.PRE_SHIFT(PRE_SHIFT)) uut (
    .clk(clk), .rst(rst), .special_mode(special_mode), .wait_mode(wait_mode),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_div64_tick(pa_div64_tick), .ovf_pulse(ovf_pulse));

  // reference model built from the requirements
  logic [6:0]  m_pre;
  logic [15:0] m_cnt, m_rd;
  logic [3:0]  m_ctrl;
  logic        m_div, m_ovf, m_rdv;

  function automatic logic [15:0] read_value(input logic [1:0] off, input logic word,
                                             input logic [15:0] c, input logic [3:0] k);
    case (off)
      2'd0: return word ? c : {8'h00, c[15:8]};
      2'd1: return {8'h00, c[7:0]};
      2'd2: return {8'h00, k, 4'h0};
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk) begin
    logic run, step;
    run  = m_ctrl[3] && !(m_ctrl[2] && wait_mode);
    step = run && ((m_pre & MASK) == MASK);
    if (rst) begin
      m_pre <= '0; m_cnt <= '0; m_rd <= '0; m_ctrl <= '0;
      m_div <= 1'b0; m_ovf <= 1'b0; m_rdv <= 1'b0;
    end else begin
      if (run) m_pre <= m_pre + 7'd1;
      m_div <= run && (m_pre[5:0] == 6'h3F);
      m_ovf <= 1'b0;
      if (bus_wr && special_mode && bus_addr == 2'd0 && bus_word)
        m_cnt <= bus_wdata;
      else if (bus_wr && special_mode && bus_addr == 2'd0)
        m_cnt <= {bus_wdata[7:0], m_cnt[7:0]};
      else if (bus_wr && special_mode && bus_addr == 2'd1)
        m_cnt <= {m_cnt[15:8], bus_wdata[7:0]};
      else if (step) begin
        m_cnt <= m_cnt + 16'd1;
        m_ovf <= (m_cnt == 16'hFFFF);
      end
      if (bus_wr && bus_addr == 2'd2) m_ctrl <= bus_wdata[7:4];
      m_rdv <= bus_rd;
      if (bus_rd) m_rd <= read_value(bus_addr, bus_word, m_cnt, m_ctrl);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking && !rst) begin
      chk(pa_div64_tick == m_div, "R9 div64 tick", 16'(pa_div64_tick), 16'(m_div));
      chk(ovf_pulse == m_ovf, "R3 overflow strobe", 16'(ovf_pulse), 16'(m_ovf));
      if (m_rdv) chk(bus_rdata == m_rd, "R6 read data vs model", bus_rdata, m_rd);
    end
  end

  task automatic wr(input logic [1:0] off, input logic word, input logic [15:0] d);
    @(negedge clk);
    bus_addr = off; bus_word = word; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] off, input logic word, output logic [15:0] d);
    @(negedge clk);
    bus_addr = off; bus_word = word; bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic count_ticks(input int n, output int ticks);
    ticks = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pa_div64_tick) ticks++;
    end
  endtask

  initial begin
    logic [15:0] a, b;
    int t;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; checking = 1'b1;

    // R1 reset state
    chk(pa_div64_tick == 1'b0 && ovf_pulse == 1'b0, "R1 outputs after reset",
        16'({pa_div64_tick, ovf_pulse}), 16'h0);
    rd(2'd0, 1'b1, a); chk(a == 16'h0000, "R1 counter reset", a, 16'h0000);
    rd(2'd2, 1'b0, a); chk(a == 16'h0000, "R1 control reset", a, 16'h0000);

    // R7 control layout
    wr(2'd2, 1'b0, 16'h003F);
    rd(2'd2, 1'b0, a); chk(a == 16'h0030, "R7 spare bits kept, low nibble zero", a, 16'h0030);
    rd(2'd3, 1'b0, a); chk(a == 16'h0000, "R7 offset 3 reads zero", a, 16'h0000);

    // R4 normal-mode writes ignored (timer stopped)
    wr(2'd0, 1'b1, 16'h1234);
    wr(2'd1, 1'b0, 16'h0077);
    rd(2'd0, 1'b1, a); chk(a == 16'h0000, "R4 normal write ignored", a, 16'h0000);

    // R5 special-mode loads
    special_mode = 1'b1;
    wr(2'd0, 1'b1, 16'hABCD);
    rd(2'd0, 1'b1, a); chk(a == 16'hABCD, "R5 word load", a, 16'hABCD);
    wr(2'd0, 1'b0, 16'h0012);
    rd(2'd0, 1'b1, a); chk(a == 16'h12CD, "R5 high byte load", a, 16'h12CD);
    wr(2'd1, 1'b0, 16'h0034);
    rd(2'd1, 1'b0, a); chk(a == 16'h0034, "R6 low byte read", a, 16'h0034);
    rd(2'd0, 1'b0, a); chk(a == 16'h0012, "R6 high byte read", a, 16'h0012);
    special_mode = 1'b0;

    // R8 disabled: nothing moves
    count_ticks(200, t); chk(t == 0, "R8 no div64 while disabled", 16'(t), 16'd0);
    rd(2'd0, 1'b1, a); chk(a == 16'h1234, "R8 counter held", a, 16'h1234);

    // R2 counting rate: enable, 40 edges -> 10 steps
    wr(2'd2, 1'b0, 16'h0080);
    repeat (40) @(posedge clk);
    rd(2'd0, 1'b1, a); chk(a == 16'h123E, "R2 count rate", a, 16'h123E);

    // R9 one pulse per 64 clocks
    count_ticks(640, t); chk(t == 10, "R9 div64 rate", 16'(t), 16'd10);

    // R10 stop in wait
    wr(2'd2, 1'b0, 16'h00C0);
    wait_mode = 1'b1;
    rd(2'd0, 1'b1, a);
    count_ticks(100, t); chk(t == 0, "R10 no div64 in wait stop", 16'(t), 16'd0);
    rd(2'd0, 1'b1, b); chk(a == b, "R10 counter frozen in wait", b, a);
    wr(2'd2, 1'b0, 16'h0080);
    rd(2'd0, 1'b1, a);
    repeat (100) @(posedge clk);
    rd(2'd0, 1'b1, b);
    chk((b - a) >= 16'd24 && (b - a) <= 16'd26, "R10 runs in wait without stop bit",
        b - a, 16'd25);
    wait_mode = 1'b0;

    // R3 wrap
    special_mode = 1'b1;
    wr(2'd0, 1'b1, 16'hFFFE);
    special_mode = 1'b0;
    t = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (ovf_pulse) t++;
    end
    chk(t == 1, "R3 single overflow pulse", 16'(t), 16'd1);
    rd(2'd0, 1'b1, a); chk(a <= 16'h0004, "R3 wrapped to zero", a, 16'h0002);

    // random traffic against the model (R5, R6, R2)
    for (int i = 0; i < 6000; i++) begin
      int r;
      @(negedge clk);
      r = $urandom % 100;
      bus_addr  = 2'($urandom % 4);
      bus_word  = 1'($urandom % 2);
      bus_wdata = 16'($urandom);
      bus_rd    = (r < 55);
      bus_wr    = (r >= 55 && r < 70);
      if (bus_wr && bus_addr == 2'd2 && ($urandom % 4 != 0)) bus_wdata[7] = 1'b1;
      if ($urandom % 8 == 0) special_mode = ~special_mode;
      if ($urandom % 16 == 0) wait_mode = ~wait_mode;
    end
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule